// File: doc/BRIEF.md
# Configuration Data Write Port

This block is the write-only data window through which a bus master streams a device configuration image into a configuration engine. Software writes the image as 32-bit words. If the image length is not a multiple of four bytes, it is zero-padded before it reaches the port. Each word holds four consecutive image bytes, and the earliest byte sits in bits 7:0. The port occupies a single register at offset 0x0. The surrounding fabric does the address decoding, so the port has no address inputs. Its only storage is one word-wide slot, which resets to zero.

Each word is placed in the slot and released downstream only when the target can take it. In full-configuration mode the port waits until the target reports that it has left reset and is in its configuration phase. The word then leaves as one 32-bit beat. In partial-reconfiguration mode the port waits for the target's ready input. The word then leaves as two 16-bit beats: the low half first, then the high half. If ready drops between the two halves, the second half waits. Reads of the register are refused with a slave-error response and zero data.

The write response is held back until the slot is free, so the master is throttled and no word is lost. The mode is captured together with each word.

Top module: `cfg_data_port`

## Requirements
- R1: A write is accepted (s_awready and s_wready high) in a cycle where s_awvalid and s_wvalid are both high, the slot is empty and no response is pending. s_bvalid rises on the next cycle with s_bresp = 2'b00 and holds, with s_bresp unchanged, until s_bready is seen.
- R2: An accepted read (s_arvalid and s_arready) raises s_rvalid on the next cycle with s_rdata = 0 and s_rresp = 2'b10, held until s_rready. s_arready is low while a read response is pending.
- R3: A word written with mode_partial = 0 leaves as one beat: m_data carries all 32 bits unchanged and m_narrow = 0.
- R4: A word written with mode_partial = 1 leaves as two beats with m_narrow = 1. Bits 15:0 go first and bits 31:16 second, each placed in m_data[15:0] with m_data[31:16] = 0.
- R5: A full-mode beat appears on m_valid only in the cycle after tgt_cfg_phase was seen high. While tgt_cfg_phase stays low, the word stays held.
- R6: A partial-mode beat appears only in the cycle after tgt_pr_ready was seen high. If tgt_pr_ready falls after the first half is taken, the second half waits until it returns.
- R7: While m_valid is high and m_ready is low, m_valid, m_data and m_narrow stay unchanged.
- R8: No new write is accepted while a previous word still has beats to deliver. Every accepted word is delivered exactly once, in write order.
- R9: The mode is sampled when the write is accepted. Changing mode_partial while a word waits does not change how that word is split.
- R10: While rst is high and on the first cycle after it, m_valid, s_bvalid and s_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | 32 | Image word, little-endian byte order |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read request valid |
| s_arready | output | 1 | Read request accepted |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response taken |
| s_rdata | output | 32 | Read data (always zero) |
| s_rresp | output | 2 | Read response code (slave error) |
| mode_partial | input | 1 | 1 = partial reconfiguration, 0 = full configuration |
| tgt_cfg_phase | input | 1 | Target is in its configuration phase |
| tgt_pr_ready | input | 1 | Target ready for partial-reconfiguration data |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream beat accepted |
| m_data | output | 32 | Downstream beat data |
| m_narrow | output | 1 | Beat carries a 16-bit half in bits 15:0 |

## Verification
Write and read responses are due one cycle after the accepting edge. A beat appears one cycle after the edge at which the slot was full and the mode's readiness input was high. The second partial half comes at the earliest two edges after the first half is taken. The bench drives every input at the falling edge and samples the outputs a moment later. Each check therefore looks at the state settled by the rising edge it counts toward. During random traffic, a queue of expected beats is filled at the moment each write is accepted, with the mode as it was then. The queue is drained only on sampled valid-and-ready cycles.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    parameter int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_FULL    = 1'b0,
        MODE_PARTIAL = 1'b1
    } cfg_mode_e;

    // one buffered image word together with the mode captured at acceptance
    typedef struct packed {
        cfg_mode_e mode;
        word_t     data;
    } slot_t;

    // one downstream beat
    typedef struct packed {
        logic  narrow;
        word_t data;
    } beat_t;

    // build the beat for a slot; upper selects the second half in partial mode
    function automatic beat_t make_beat(slot_t s, logic upper);
        beat_t b;
        if (s.mode == MODE_PARTIAL) begin
            b.narrow = 1'b1;
            b.data   = '0;
            b.data[HALF_W-1:0] = upper ? s.data[WORD_W-1:HALF_W] : s.data[HALF_W-1:0];
        end else begin
            b.narrow = 1'b0;
            b.data   = s.data;
        end
        return b;
    endfunction

endpackage

// File: rtl/cfgp_wr_slot.sv
module cfgp_wr_slot
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        awvalid,
    input  logic        wvalid,
    input  word_t       wdata,
    input  logic        mode_sel,
    input  logic        bready,
    input  logic        slot_release,
    output logic        awready,
    output logic        wready,
    output logic        bvalid,
    output logic [1:0]  bresp,
    output logic        slot_full,
    output slot_t       slot
);

    logic  full_q;
    logic  bvalid_q;
    slot_t slot_q;
    logic  take;

    // accept only into an empty slot with no response outstanding
    assign take    = awvalid && wvalid && !full_q && !bvalid_q;
    assign awready = take;
    assign wready  = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= 1'b0;
            slot_q   <= '0;
            bvalid_q <= 1'b0;
        end else begin
            if (take) begin
                slot_q.data <= wdata;
                slot_q.mode <= mode_sel ? MODE_PARTIAL : MODE_FULL;
                full_q      <= 1'b1;
            end else if (slot_release) begin
                full_q      <= 1'b0;
            end

            if (take) begin
                bvalid_q <= 1'b1;
            end else if (bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

    assign bvalid    = bvalid_q;
    assign bresp     = RESP_OKAY;
    assign slot_full = full_q;
    assign slot      = slot_q;

endmodule

// File: rtl/cfgp_rd_reject.sv
module cfgp_rd_reject
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arvalid,
    input  logic        rready,
    output logic        arready,
    output logic        rvalid,
    output word_t       rdata,
    output logic [1:0]  rresp
);

    logic rvalid_q;

    assign arready = !rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
        end else if (arvalid && !rvalid_q) begin
            rvalid_q <= 1'b1;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = '0;
    assign rresp  = RESP_SLVERR;

endmodule

// File: rtl/cfgp_beat_out.sv
module cfgp_beat_out
    import cfgp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   slot_full,
    input  slot_t  slot,
    input  logic   tgt_cfg_phase,
    input  logic   tgt_pr_ready,
    input  logic   m_ready,
    output logic   m_valid,
    output word_t  m_data,
    output logic   m_narrow,
    output logic   slot_release
);

    beat_t out_q;
    logic  valid_q;
    logic  upper_q;
    logic  gate;
    logic  load;
    logic  fire;

    // readiness condition depends on the mode stored with the word
    assign gate = (slot.mode == MODE_PARTIAL) ? tgt_pr_ready : tgt_cfg_phase;
    assign load = slot_full && !valid_q && gate;
    assign fire = valid_q && m_ready;

    // word is finished after the full beat or after the upper half
    assign slot_release = fire && (!out_q.narrow || upper_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
            upper_q <= 1'b0;
        end else if (load) begin
            out_q   <= make_beat(slot, upper_q);
            valid_q <= 1'b1;
        end else if (fire) begin
            valid_q <= 1'b0;
            upper_q <= out_q.narrow && !upper_q;
        end
    end

    assign m_valid  = valid_q;
    assign m_data   = out_q.data;
    assign m_narrow = out_q.narrow;

endmodule

// File: rtl/cfg_data_port.sv
module cfg_data_port
    import cfgp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic               s_wvalid,
    output logic               s_wready,
    input  logic [WORD_W-1:0]  s_wdata,
    output logic               s_bvalid,
    input  logic               s_bready,
    output logic [1:0]         s_bresp,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic [WORD_W-1:0]  s_rdata,
    output logic [1:0]         s_rresp,
    input  logic               mode_partial,
    input  logic               tgt_cfg_phase,
    input  logic               tgt_pr_ready,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [WORD_W-1:0]  m_data,
    output logic               m_narrow
);

    logic  slot_full;
    logic  slot_release;
    slot_t slot;

    cfgp_wr_slot u_wr (
        .clk          (clk),
        .rst          (rst),
        .awvalid      (s_awvalid),
        .wvalid       (s_wvalid),
        .wdata        (s_wdata),
        .mode_sel     (mode_partial),
        .bready       (s_bready),
        .slot_release (slot_release),
        .awready      (s_awready),
        .wready       (s_wready),
        .bvalid       (s_bvalid),
        .bresp        (s_bresp),
        .slot_full    (slot_full),
        .slot         (slot)
    );

    cfgp_rd_reject u_rd (
        .clk     (clk),
        .rst     (rst),
        .arvalid (s_arvalid),
        .rready  (s_rready),
        .arready (s_arready),
        .rvalid  (s_rvalid),
        .rdata   (s_rdata),
        .rresp   (s_rresp)
    );

    cfgp_beat_out u_out (
        .clk           (clk),
        .rst           (rst),
        .slot_full     (slot_full),
        .slot          (slot),
        .tgt_cfg_phase (tgt_cfg_phase),
        .tgt_pr_ready  (tgt_pr_ready),
        .m_ready       (m_ready),
        .m_valid       (m_valid),
        .m_data        (m_data),
        .m_narrow      (m_narrow),
        .slot_release  (slot_release)
    );

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               s_awvalid,
    input logic               s_awready,
    input logic               s_wvalid,
    input logic               s_bvalid,
    input logic               s_bready,
    input logic [1:0]         s_bresp,
    input logic               s_arvalid,
    input logic               s_arready,
    input logic               s_rvalid,
    input logic               s_rready,
    input logic               tgt_cfg_phase,
    input logic               tgt_pr_ready,
    input logic               m_valid,
    input logic               m_ready,
    input logic [WORD_W-1:0]  m_data,
    input logic               m_narrow
);

    p_accept_resp_r1: assert property (@(posedge clk) disable iff (rst)
        (s_awvalid && s_wvalid && s_awready) |=> s_bvalid);

    p_resp_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

    p_read_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (s_arvalid && s_arready) |=> s_rvalid);

    p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> s_rvalid);

    p_narrow_pad_r4: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_narrow) |-> (m_data[WORD_W-1:HALF_W] == '0));

    p_full_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(m_valid) && !m_narrow) |-> $past(tgt_cfg_phase));

    p_pr_gate_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(m_valid) && m_narrow) |-> $past(tgt_pr_ready));

    p_beat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_narrow)));

endmodule

bind cfg_data_port cfgp_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .s_awvalid     (s_awvalid),
    .s_awready     (s_awready),
    .s_wvalid      (s_wvalid),
    .s_bvalid      (s_bvalid),
    .s_bready      (s_bready),
    .s_bresp       (s_bresp),
    .s_arvalid     (s_arvalid),
    .s_arready     (s_arready),
    .s_rvalid      (s_rvalid),
    .s_rready      (s_rready),
    .tgt_cfg_phase (tgt_cfg_phase),
    .tgt_pr_ready  (tgt_pr_ready),
    .m_valid       (m_valid),
    .m_ready       (m_ready),
    .m_data        (m_data),
    .m_narrow      (m_narrow)
);

// File: tb/tb_cfg_data_port.sv
`timescale 1ns/1ps
module tb_cfg_data_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b1;
    logic        s_arvalid = 1'b0, s_rready = 1'b1;
    logic [31:0] s_wdata = '0;
    logic        mode_partial = 1'b0, tgt_cfg_phase = 1'b0, tgt_pr_ready = 1'b0;
    logic        m_ready = 1'b0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata, m_data;
    logic        m_valid, m_narrow;

    int checks = 0;
    int errors = 0;
    int words_in = 0;
    bit stop = 1'b0;
    logic [32:0] exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    cfg_data_port dut (
        .clk(clk), .rst(rst),
        .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rvalid(s_rvalid), .s_rready(s_rready),
        .s_rdata(s_rdata), .s_rresp(s_rresp),
        .mode_partial(mode_partial), .tgt_cfg_phase(tgt_cfg_phase),
        .tgt_pr_ready(tgt_pr_ready),
        .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_narrow(m_narrow)
    );

    function automatic logic [32:0] full_beat(input logic [31:0] w);
        return {1'b0, w};
    endfunction
    function automatic logic [32:0] lo_beat(input logic [31:0] w);
        return {1'b1, 16'h0000, w[15:0]};
    endfunction
    function automatic logic [32:0] hi_beat(input logic [31:0] w);
        return {1'b1, 16'h0000, w[31:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // present one word, wait for acceptance, record expected beats
    task automatic write_word(input logic [31:0] w, input bit pm, input bit check_resp);
        int wait_n;
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_wdata = w; mode_partial = pm;
        #1;
        wait_n = 0;
        while (!s_awready && wait_n < 2000) begin
            @(negedge clk); #1; wait_n++;
        end
        if (pm) begin
            exp_q.push_back(lo_beat(w));
            exp_q.push_back(hi_beat(w));
        end else begin
            exp_q.push_back(full_beat(w));
        end
        words_in++;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        mode_partial = 1'($urandom);   // R9: mode moves after capture
        if (check_resp)
            chk(s_bvalid && s_bresp == 2'b00, "R1 response after accept",
                {s_bvalid, s_bresp}, 3'b100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd5813));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!m_valid && !s_bvalid && !s_rvalid, "R10 outputs in reset",
            {m_valid, s_bvalid, s_rvalid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!m_valid && !s_bvalid && !s_rvalid && !s_awready, "R10 after reset",
            {m_valid, s_bvalid, s_rvalid, s_awready}, 0);

        // R2: read is refused
        s_rready = 1'b0;
        s_arvalid = 1'b1; #1;
        chk(s_arready, "R2 arready idle", s_arready, 1);
        @(negedge clk); s_arvalid = 1'b0;
        chk(s_rvalid && s_rdata == 0 && s_rresp == 2'b10, "R2 read error",
            {s_rvalid, s_rresp, s_rdata}, {1'b1, 2'b10, 32'h0});
        @(negedge clk);
        chk(s_rvalid && !s_arready, "R2 held until rready", {s_rvalid, s_arready}, 2'b10);
        s_rready = 1'b1;
        @(negedge clk);
        chk(!s_rvalid, "R2 released", s_rvalid, 0);

        // R5/R3/R7/R1: full mode held until config phase
        tgt_cfg_phase = 1'b0; m_ready = 1'b0; s_bready = 1'b0;
        write_word(32'hA1B2_C3D4, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!m_valid, "R5 no beat before config phase", m_valid, 0);
            chk(s_bvalid, "R1 response held without bready", s_bvalid, 1);
        end
        s_bready = 1'b1;
        tgt_cfg_phase = 1'b1;
        @(negedge clk);
        chk(m_valid && !m_narrow && m_data == 32'hA1B2_C3D4, "R3 full beat",
            {m_valid, m_narrow, m_data}, {2'b10, 32'hA1B2_C3D4});
        chk(!s_bvalid, "R1 response cleared", s_bvalid, 0);
        repeat (2) begin
            @(negedge clk);
            chk(m_valid && m_data == 32'hA1B2_C3D4, "R7 beat held", {m_valid, m_data},
                {1'b1, 32'hA1B2_C3D4});
        end
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        chk(!m_valid, "R3 beat taken", m_valid, 0);

        // R8: second write blocked while word pending
        write_word(32'h1111_2222, 1'b0, 1'b1);
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_wdata = 32'h3333_4444; mode_partial = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(!s_awready, "R8 write held off", s_awready, 0);
            @(negedge clk);
        end
        chk(m_valid && m_data == 32'h1111_2222, "R8 first word out", m_data, 32'h1111_2222);
        m_ready = 1'b1;
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        write_word(32'h3333_4444, 1'b0, 1'b0);
        for (int i = 0; i < 10 && !m_valid; i++) @(negedge clk);
        chk(m_valid && m_data == 32'h3333_4444, "R8 second word in order", m_data, 32'h3333_4444);
        @(negedge clk);
        m_ready = 1'b0;

        // R4/R6/R9: partial mode halves with ready dropping between
        tgt_cfg_phase = 1'b0; tgt_pr_ready = 1'b1;
        write_word(32'h1234_ABCD, 1'b1, 1'b1);
        mode_partial = 1'b0;
        @(negedge clk);
        chk(m_valid && m_narrow && m_data == 32'h0000_ABCD, "R4 low half first",
            {m_valid, m_narrow, m_data}, {2'b11, 32'h0000_ABCD});
        m_ready = 1'b1; tgt_pr_ready = 1'b0;
        @(negedge clk);
        m_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!m_valid, "R6 second half paused", m_valid, 0);
        end
        tgt_pr_ready = 1'b1;
        @(negedge clk);
        chk(m_valid && m_narrow && m_data == 32'h0000_1234, "R9 R4 high half after mode flip",
            {m_valid, m_narrow, m_data}, {2'b11, 32'h0000_1234});
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        chk(!m_valid, "R4 word done", m_valid, 0);
        exp_q.delete();

        // random traffic against the expected-beat queue
        fork
            begin
                for (int n = 0; n < 200; n++)
                    write_word($urandom, 1'($urandom), 1'b1);
                for (int t = 0; t < 5000 && exp_q.size() != 0; t++) @(negedge clk);
                stop = 1'b1;
            end
            begin
                while (!stop) begin
                    @(negedge clk);
                    m_ready       = ($urandom % 4) != 0;
                    tgt_cfg_phase = ($urandom % 4) != 0;
                    tgt_pr_ready  = ($urandom % 4) != 0;
                    #1;
                    if (m_valid && m_ready) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R8 unexpected beat", {m_narrow, m_data}, 0);
                        end else begin
                            logic [32:0] e;
                            e = exp_q.pop_front();
                            chk({m_narrow, m_data} == e, e[32] ? "R4 random half" : "R3 random word",
                                {m_narrow, m_data}, e);
                        end
                    end
                end
            end
        join
        chk(exp_q.size() == 0, "R8 every word delivered", exp_q.size(), 0);
        summary();
    end

endmodule